// File: doc/BRIEF.md
# Converter Clock Prescaler

This block derives a slow clock for a converter sequencer from the system clock. It has two divider stages. The first stage is a modulus counter. It runs with a ratio of the programmed select value plus one, so the ratio can be any integer from 2 to 32. The counter emits a one-cycle terminal pulse each time it wraps. The second stage is a toggle flip-flop that flips on every terminal pulse. Because of this, the output clock always has an even period of 4 to 64 system clocks and a 50% duty cycle.

The ratio is loaded through a write strobe. Each write captures the new select value and clears both stages in the same cycle, so the new ratio starts from a known low phase. The block also gives the sequencer a single-cycle enable. This enable is high during the first system clock of every high phase of the output. Logic in the system clock domain can use it instead of detecting the divided clock's edges itself.

Top module: `conv_clk_prescaler`

## Requirements
- R1: While `rstN` is low, and in the cycle after it is released, `clkOut` and `riseEn` are 0. After reset the captured select value is 1, which gives a half period of 2 system clocks.
- R2: For a captured select value S from 1 to 31, the half period of `clkOut` is S+1 system clocks.
- R3: A captured select value of 0 behaves exactly like a value of 1, with a half period of 2.
- R4: After a write or reset, `clkOut` is low for N cycles, then high for N cycles, and this repeats, where N is the half period. The output period is 2N and its duty cycle is exactly 50%.
- R5: `riseEn` is high for exactly one system clock per output period. That clock is the first cycle in which `clkOut` is 1, and `riseEn` is 0 in all other cycles.
- R6: When `divWrite` is 1 at a clock edge, `divSel` is captured at that edge and both stages are cleared. From the following cycle, `clkOut` is low and the low phase restarts with the new ratio. This also holds when the write arrives while `clkOut` is high.
- R7: A change on `divSel` while `divWrite` is 0 has no effect on `clkOut` or `riseEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| divSel | input | 5 | Prescale select value (ratio = value + 1, 0 treated as 1) |
| divWrite | input | 1 | Capture strobe for `divSel`, also clears both stages |
| clkOut | output | 1 | Divided clock with 50% duty cycle |
| riseEn | output | 1 | One-cycle enable in the first high cycle of `clkOut` |

## Verification
If the modulus counter goes wrong, it shows up at `clkOut` as a high or low run of the wrong length. This is visible on the very next output edge, at most N cycles after the fault. If the toggle stage goes wrong, the phase after a write is wrong, and `clkOut` differs from the model in the cycle right after the write. If the enable is mistimed, it appears as `riseEn` arriving one cycle early or late relative to the rising output edge. Comparing the outputs against a model on every clock therefore finds each of these faults within one half period.

// File: rtl/conv_clk_prescaler_pkg.sv
package conv_clk_prescaler_pkg;
  // Strobes passed from the modulus control to the toggle datapath.
  typedef struct packed {
    logic clear; // synchronous restart of the output phase
    logic tick;  // one-cycle terminal pulse of the first stage
  } stageStrobes_t;
endpackage

// File: rtl/conv_clk_ctrl.sv
module conv_clk_ctrl
  import conv_clk_prescaler_pkg::*;
#(
  parameter int SEL_W     = 5,
  parameter int RESET_SEL = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] divSel,
  input  logic             divWrite,
  output stageStrobes_t    strobes
);
  localparam logic [SEL_W-1:0] SEL_ONE   = SEL_W'(1);
  localparam logic [SEL_W-1:0] SEL_RESET = SEL_W'(RESET_SEL);

  logic [SEL_W-1:0] fieldQ;
  logic [SEL_W-1:0] countQ;
  logic [SEL_W-1:0] limit;

  // A zero select is reserved and is mapped onto the smallest ratio.
  always_comb begin
    limit = (fieldQ == '0) ? SEL_ONE : fieldQ;
  end

  always_comb begin
    strobes.clear = divWrite;
    strobes.tick  = !divWrite && (countQ == limit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fieldQ <= SEL_RESET;
      countQ <= '0;
    end else if (divWrite) begin
      fieldQ <= divSel;
      countQ <= '0;
    end else if (countQ == limit) begin
      countQ <= '0;
    end else begin
      countQ <= countQ + SEL_ONE;
    end
  end

  // R2: the count never passes the active modulus limit.
  a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rstN)
    countQ <= limit);

  // R7: the held select only moves on a write.
  a_r7_field_held: assert property (@(posedge clk) disable iff (!rstN)
    !divWrite |=> $stable(fieldQ));

  // R6: a write restarts the count from zero.
  a_r6_write_restarts: assert property (@(posedge clk) disable iff (!rstN)
    divWrite |=> countQ == '0);
endmodule

// File: rtl/conv_clk_toggle.sv
module conv_clk_toggle
  import conv_clk_prescaler_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  stageStrobes_t strobes,
  output logic          clkOut,
  output logic          riseEn
);
  logic togQ;
  logic riseQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      togQ  <= 1'b0;
      riseQ <= 1'b0;
    end else if (strobes.clear) begin
      togQ  <= 1'b0;
      riseQ <= 1'b0;
    end else begin
      if (strobes.tick) togQ <= !togQ;
      riseQ <= strobes.tick && !togQ;
    end
  end

  assign clkOut = togQ;
  assign riseEn = riseQ;

  // R4: the output only moves on a terminal pulse or a restart.
  a_r4_toggle_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.tick && !strobes.clear) |=> $stable(togQ));

  // R5: the enable sits on the first high cycle and lasts one cycle.
  a_r5_rise_aligned: assert property (@(posedge clk) disable iff (!rstN)
    $rose(togQ) |-> riseQ);
  a_r5_rise_single: assert property (@(posedge clk) disable iff (!rstN)
    riseQ |=> !riseQ);

  // R6: a restart leaves the output low in the next cycle.
  a_r6_clear_low: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clear |=> (!togQ && !riseQ));
endmodule

// File: rtl/conv_clk_prescaler.sv
module conv_clk_prescaler
  import conv_clk_prescaler_pkg::*;
#(
  parameter int SEL_W     = 5,
  parameter int RESET_SEL = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] divSel,
  input  logic             divWrite,
  output logic             clkOut,
  output logic             riseEn
);
  stageStrobes_t strobes;

  conv_clk_ctrl #(
    .SEL_W    (SEL_W),
    .RESET_SEL(RESET_SEL)
  ) ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .divSel  (divSel),
    .divWrite(divWrite),
    .strobes (strobes)
  );

  conv_clk_toggle stage2 (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .clkOut (clkOut),
    .riseEn (riseEn)
  );

  // R1: nothing leaves the block in the cycle after reset.
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |=> (!clkOut && !riseEn));
endmodule

// File: tb/conv_clk_prescaler_test.sv
module conv_clk_prescaler_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] divSel = 5'd0;
  logic       divWrite = 1'b0;
  logic       clkOut;
  logic       riseEn;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;
  string curReq = "R1";

  // Behavioural model: select held, cycles since last restart.
  int mField = 1;
  int cyc = 0;

  conv_clk_prescaler uut (
    .clk(clk), .rstN(rstN), .divSel(divSel), .divWrite(divWrite),
    .clkOut(clkOut), .riseEn(riseEn)
  );

  always #4 clk = !clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rstN) begin
      mField = 1; cyc = 0;
    end else if (divWrite) begin
      mField = divSel; cyc = 0;
    end else begin
      cyc = cyc + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      int n;
      int expClk;
      int expRise;
      n = ((mField == 0) ? 1 : mField) + 1;
      expClk = (cyc / n) % 2;
      expRise = (cyc % (2 * n) == n) ? 1 : 0;
      check(curReq, int'(clkOut), expClk, "clkOut");
      check((curReq == "R4") ? "R5" : curReq, int'(riseEn), expRise, "riseEn");
    end
  end

  task automatic writeSel(input logic [4:0] v);
    @(negedge clk);
    divSel = v; divWrite = 1'b1;
    @(negedge clk);
    divWrite = 1'b0;
  endtask

  initial begin
    // R1: reset state and default ratio
    curReq = "R1";
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (12) @(negedge clk);
    // R2: several ratios including the extremes
    curReq = "R2";
    writeSel(5'd1);  repeat (10) @(negedge clk);
    writeSel(5'd5);  repeat (30) @(negedge clk);
    writeSel(5'd31); repeat (140) @(negedge clk);
    writeSel(5'd17); repeat (80) @(negedge clk);
    // R3: zero select acts as one
    curReq = "R3";
    writeSel(5'd0);  repeat (12) @(negedge clk);
    // R4 / R5: duty cycle and enable over several periods
    curReq = "R4";
    writeSel(5'd2);  repeat (30) @(negedge clk);
    writeSel(5'd9);  repeat (60) @(negedge clk);
    // R6: write while output high restarts low with new ratio
    curReq = "R6";
    writeSel(5'd6);
    while (clkOut !== 1'b1) @(negedge clk);
    repeat (2) @(negedge clk);
    writeSel(5'd3);
    check("R6", int'(clkOut), 0, "clkOut after write while high");
    repeat (20) @(negedge clk);
    // R7: select changes without a write are ignored
    curReq = "R7";
    writeSel(5'd4);
    repeat (3) @(negedge clk);
    divSel = 5'd30; repeat (7) @(negedge clk);
    divSel = 5'd0;  repeat (9) @(negedge clk);
    divSel = 5'd1;  repeat (12) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    done = 1'b1;
    total++; bad++;
    $display("FAIL watchdog run did not finish actual=%0d expected=%0d", cycles, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule